// File: doc/BRIEF.md
# Dual-Converter Parallel Sample Capture with Alternating Frame Buffers

This block receives samples from two synchronized 16-bit parallel converters that share a single active-low data-ready strobe. Each converter also supplies an out-of-range flag. On every falling edge of the strobe, the block takes both converter words and both flags together as one sample. It then writes that sample through a simple memory write port into one of two frame buffers. The strobe is asynchronous to the system clock. It is brought in through a two-flop synchronizer and edge-detected. The data bus is registered one cycle after the detected edge, so it is sampled while it is stable. The converter select and read-enable outputs are held low at all times.

Samples are counted against a frame length that software can set. Values outside the legal window are clamped to the nearest limit. When the last sample of a frame has been stored, the block does three things: it pulses a frame interrupt, marks that buffer as full, and moves on to the other buffer without losing a sample. The consumer hands a buffer back by pulsing its release line.

If the buffer that would be filled next is still held by the consumer, a sticky overrun flag is set. The following frame is then discarded instead of overwriting held data. Two storage layouts are available: three 32-bit words per sample in narrow mode, or two words per sample in wide mode.

Top module: `adc_pingpong_capture`

## Requirements
- R1: A sample is captured only on a high-to-low transition of `adc_drdy_n`; a rising edge or a held level captures nothing, so each strobe cycle causes exactly one sample's worth of writes.
- R2: With `cfg_wide`=0 a sample occupies three consecutive words: converter A data (zero-extended), converter B data (zero-extended), then a word with A's out-of-range flag in bit 0, B's in bit 1 and all other bits zero.
- R3: With `cfg_wide`=1 a sample occupies two consecutive words: first {B data in bits 31:16, A data in bits 15:0}, then a word with A's flag in bit 0, B's in bit 1 and the rest zero.
- R4: The write address is {buffer select in the MSB, sample index times words-per-sample plus word number}. Buffer 0 is ping and buffer 1 is pong. `stat_index` shows how many samples of the current frame have been taken.
- R5: A frame length below FRAME_MIN is treated as FRAME_MIN, and one above FRAME_MAX is treated as FRAME_MAX.
- R6: Frame length and layout are sampled only at the first sample of a frame. A change made mid-frame has no effect on the frame in progress.
- R7: After the final word of a frame's last sample, `frame_irq` pulses for one cycle. At the same time `stat_fill_buf` reports that buffer, and capture continues into the other buffer.
- R8: If the next buffer is still full (not released) when a frame completes, `stat_overrun` is set and stays set. The next frame's samples are not written, and that same buffer is retried at the end of the discarded frame.
- R9: A release pulse for the next buffer that arrives in the very cycle a frame completes counts as a release: no overrun is raised, and the following frame is written.
- R10: Pulsing `ovr_clr` clears `stat_overrun`. If a new overrun occurs in the same cycle, the flag stays set.
- R11: After reset, `mem_we`, `frame_irq`, `stat_index`, `stat_fill_buf` and `stat_overrun` are zero. `adc_cs_n` and `adc_rd_n` are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_drdy_n | input | 1 | Shared asynchronous data-ready strobe, active low |
| adc_a_data | input | SAMPLE_W | Converter A parallel data |
| adc_b_data | input | SAMPLE_W | Converter B parallel data |
| adc_a_ovr | input | 1 | Converter A out-of-range flag |
| adc_b_ovr | input | 1 | Converter B out-of-range flag |
| cfg_frame_len | input | LW | Requested samples per frame |
| cfg_wide | input | 1 | 1 = two-word layout, 0 = three-word layout |
| buf_release | input | 2 | Per-buffer release pulse from the consumer |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| adc_cs_n | output | 1 | Converter chip select, held low |
| adc_rd_n | output | 1 | Converter read enable, held low |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | AW+1 | Buffer memory address, MSB selects the buffer |
| mem_wdata | output | 2*SAMPLE_W | Buffer memory write data |
| frame_irq | output | 1 | One-cycle frame-complete pulse |
| stat_fill_buf | output | 1 | Buffer most recently completed |
| stat_index | output | LW | Samples taken in the current frame |
| stat_overrun | output | 1 | Sticky overrun flag |

## Verification
Two events can land in the same clock cycle: a frame completing, and the consumer releasing the buffer that comes next. To provoke this, the bench watches the write port for the final word of a frame. When it sees that word, it drives the pong release line, so the pulse is sampled on the very edge at which the frame completes. The case counts as correct when the cleared overrun flag stays clear and the next sample appears in the pong buffer. The bench also tests the opposite outcome: a buffer that is never released leads to a discarded frame with no writes at all.

// File: rtl/adc_pingpong_capture.sv
module adc_pingpong_capture #(
  parameter int SAMPLE_W  = 16,
  parameter int FRAME_MIN = 4096,
  parameter int FRAME_MAX = 4608,
  localparam int LW = $clog2(FRAME_MAX + 1),
  localparam int AW = $clog2(FRAME_MAX * 3),
  localparam int DW = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adc_drdy_n,
  input  logic [SAMPLE_W-1:0] adc_a_data,
  input  logic [SAMPLE_W-1:0] adc_b_data,
  input  logic                adc_a_ovr,
  input  logic                adc_b_ovr,
  input  logic [LW-1:0]       cfg_frame_len,
  input  logic                cfg_wide,
  input  logic [1:0]          buf_release,
  input  logic                ovr_clr,
  output logic                adc_cs_n,
  output logic                adc_rd_n,
  output logic                mem_we,
  output logic [AW:0]         mem_addr,
  output logic [DW-1:0]       mem_wdata,
  output logic                frame_irq,
  output logic                stat_fill_buf,
  output logic [LW-1:0]       stat_index,
  output logic                stat_overrun
);

  logic [2:0]          sync_q;
  logic                go_q;
  logic [SAMPLE_W-1:0] a_q, b_q;
  logic                oa_q, ob_q;
  logic [LW-1:0]       idx_q, len_q;
  logic                wide_q;
  logic                cur_q, drop_q, last_q, ovr_q, irq_q;
  logic [1:0]          full_q;
  logic [1:0]          ph_q;
  logic                done_q, wbuf_q, wkeep_q, wwide_q;
  logic [AW-1:0]       base_q;

  wire fall = sync_q[2] & ~sync_q[1];

  logic [LW-1:0] len_clamp;
  always_comb begin
    if (cfg_frame_len < LW'(FRAME_MIN))      len_clamp = LW'(FRAME_MIN);
    else if (cfg_frame_len > LW'(FRAME_MAX)) len_clamp = LW'(FRAME_MAX);
    else                                     len_clamp = cfg_frame_len;
  end

  wire           first    = (idx_q == '0);
  wire [LW-1:0]  len_use  = first ? len_clamp : len_q;
  wire           wide_use = first ? cfg_wide : wide_q;
  wire [AW-1:0]  idx_w    = AW'(idx_q);
  wire [AW-1:0]  base_new = wide_use ? (idx_w << 1) : (idx_w + (idx_w << 1));
  wire [1:0]     last_ph  = wwide_q ? 2'd2 : 2'd3;
  wire           cmpl     = done_q && (ph_q == last_ph);

  logic [1:0] set_full;
  logic       nxt_buf, nxt_busy;
  always_comb begin
    set_full = 2'b00;
    nxt_buf  = cur_q;
    if (cmpl && !drop_q) begin
      set_full[cur_q] = 1'b1;
      nxt_buf         = ~cur_q;
    end
    nxt_busy = full_q[nxt_buf] & ~buf_release[nxt_buf];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 3'b111;
      go_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], adc_drdy_n};
      go_q   <= fall;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; oa_q <= 1'b0; ob_q <= 1'b0;
      idx_q <= '0; len_q <= LW'(FRAME_MIN); wide_q <= 1'b0;
      base_q <= '0; wbuf_q <= 1'b0; wkeep_q <= 1'b0; wwide_q <= 1'b0;
      ph_q <= 2'd0; done_q <= 1'b0;
    end else begin
      if (go_q) begin
        a_q  <= adc_a_data;
        b_q  <= adc_b_data;
        oa_q <= adc_a_ovr;
        ob_q <= adc_b_ovr;
        if (first) begin
          len_q  <= len_clamp;
          wide_q <= cfg_wide;
        end
        base_q  <= base_new;
        wbuf_q  <= cur_q;
        wkeep_q <= ~drop_q;
        wwide_q <= wide_use;
        ph_q    <= 2'd1;
        if (idx_q + 1'b1 == len_use) begin
          idx_q  <= '0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (ph_q != 2'd0) begin
        ph_q <= (ph_q == last_ph) ? 2'd0 : ph_q + 2'd1;
        if (cmpl) done_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 2'b00;
      cur_q  <= 1'b0;
      drop_q <= 1'b0;
      last_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= (full_q & ~buf_release) | set_full;
      irq_q  <= cmpl & ~drop_q;
      ovr_q  <= (ovr_q & ~ovr_clr) | (cmpl & nxt_busy);
      if (cmpl) begin
        cur_q  <= nxt_buf;
        drop_q <= nxt_busy;
        if (!drop_q) last_q <= cur_q;
      end
    end
  end

  always_comb begin
    mem_wdata = '0;
    case ({wwide_q, ph_q})
      3'b1_01: mem_wdata = {b_q, a_q};
      3'b0_01: mem_wdata = DW'(a_q);
      3'b0_10: mem_wdata = DW'(b_q);
      3'b1_10,
      3'b0_11: mem_wdata = {{(DW-2){1'b0}}, ob_q, oa_q};
      default: mem_wdata = '0;
    endcase
  end

  assign mem_we        = (ph_q != 2'd0) & wkeep_q;
  assign mem_addr      = {wbuf_q, base_q + AW'(ph_q - 2'd1)};
  assign adc_cs_n      = 1'b0;
  assign adc_rd_n      = 1'b0;
  assign frame_irq     = irq_q;
  assign stat_fill_buf = last_q;
  assign stat_index    = idx_q;
  assign stat_overrun  = ovr_q;

endmodule

// File: rtl/adc_pingpong_capture_chk.sv
module adc_pingpong_capture_chk #(
  parameter int AW = 14,
  parameter int LW = 13,
  parameter int FRAME_MAX = 4608
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [AW:0]   mem_addr,
  input logic          frame_irq,
  input logic          stat_overrun,
  input logic          ovr_clr,
  input logic [LW-1:0] stat_index,
  input logic [1:0]    full_q
);

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  a_r7_irq_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> !mem_we);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_overrun && !ovr_clr) |=> stat_overrun);

  a_r8_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !full_q[mem_addr[AW]]);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r4_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    stat_index < LW'(FRAME_MAX));

endmodule

bind adc_pingpong_capture adc_pingpong_capture_chk #(
  .AW(AW), .LW(LW), .FRAME_MAX(FRAME_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .frame_irq(frame_irq), .stat_overrun(stat_overrun), .ovr_clr(ovr_clr),
  .stat_index(stat_index), .full_q(full_q)
);

// File: tb/adc_pingpong_capture_bench.sv
`timescale 1ns/1ps
module adc_pingpong_capture_bench;
  localparam int SW = 16;
  localparam int FMIN = 4;
  localparam int FMAX = 6;
  localparam int LW = $clog2(FMAX + 1);
  localparam int AW = $clog2(FMAX * 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drdy_n = 1'b1;
  logic [SW-1:0] a_d = '0, b_d = '0;
  logic oa = 1'b0, ob = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic cfg_wide = 1'b0;
  logic [1:0] rel_task = 2'b00, rel_auto = 2'b00;
  logic ovr_clr = 1'b0;
  logic cs_n, rd_n, mem_we, frame_irq, fill_buf, overrun;
  logic [AW:0] mem_addr;
  logic [2*SW-1:0] mem_wdata;
  logic [LW-1:0] index;

  logic arm = 1'b0;
  logic [AW:0] arm_addr = '0;
  logic [1:0] arm_mask = 2'b00;

  int total = 0, bad = 0, wcount = 0, irqcount = 0;
  logic [31:0] seen [0:63];

  always #2 clk = ~clk;

  adc_pingpong_capture #(.SAMPLE_W(SW), .FRAME_MIN(FMIN), .FRAME_MAX(FMAX)) u_adc_pingpong_capture (
    .clk(clk), .rst_n(rst_n), .adc_drdy_n(drdy_n),
    .adc_a_data(a_d), .adc_b_data(b_d), .adc_a_ovr(oa), .adc_b_ovr(ob),
    .cfg_frame_len(cfg_len), .cfg_wide(cfg_wide),
    .buf_release(rel_task | rel_auto), .ovr_clr(ovr_clr),
    .adc_cs_n(cs_n), .adc_rd_n(rd_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .frame_irq(frame_irq), .stat_fill_buf(fill_buf),
    .stat_index(index), .stat_overrun(overrun)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      seen[mem_addr] = mem_wdata;
      wcount = wcount + 1;
    end
    if (frame_irq) irqcount = irqcount + 1;
    rel_auto <= (arm && mem_we && mem_addr == arm_addr) ? arm_mask : 2'b00;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] a, input logic [15:0] b, input logic va, input logic vb);
    @(negedge clk);
    a_d = a; b_d = b; oa = va; ob = vb;
    drdy_n = 1'b0;
    repeat (8) @(negedge clk);
    drdy_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk("R11 we", 32'(mem_we), 0);
    chk("R11 irq", 32'(frame_irq), 0);
    chk("R11 index", 32'(index), 0);
    chk("R11 fill", 32'(fill_buf), 0);
    chk("R11 ovr", 32'(overrun), 0);
    chk("R11 cs", 32'(cs_n), 0);
    chk("R11 rd", 32'(rd_n), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 no strobe no write", 32'(wcount), 0);
  endtask

  task automatic t_narrow;
    cfg_len = 3'd1; cfg_wide = 1'b0;
    for (int i = 0; i < 4; i++) begin
      strobe(16'h1000 + 16'(i), 16'h2000 + 16'(i), i[0], i[1]);
      if (i == 1) chk("R4 index", 32'(index), 2);
      if (i == 2) chk("R5 clamp low no early irq", 32'(irqcount), 0);
    end
    chk("R1 writes per strobe", 32'(wcount), 12);
    for (int i = 0; i < 4; i++) begin
      chk("R2 word A", seen[3*i],   32'h1000 + 32'(i));
      chk("R2 word B", seen[3*i+1], 32'h2000 + 32'(i));
      chk("R2 ovr word", seen[3*i+2], {30'd0, i[1], i[0]});
    end
    chk("R7 irq", 32'(irqcount), 1);
    chk("R7 fill ping", 32'(fill_buf), 0);
    chk("R5 frame len clamp low", 32'(index), 0);
  endtask

  task automatic t_wide;
    cfg_len = 3'd7; cfg_wide = 1'b1;
    for (int j = 0; j < 6; j++) begin
      strobe(16'hA000 + 16'(j), 16'hB000 + 16'(j), 1'b1, j[0]);
      if (j == 2) begin cfg_len = 3'd4; cfg_wide = 1'b0; end
      if (j == 3) chk("R6 mid-frame len ignored", 32'(irqcount), 1);
    end
    chk("R5 clamp high frame done", 32'(irqcount), 2);
    chk("R7 fill pong", 32'(fill_buf), 1);
    for (int j = 0; j < 6; j++) begin
      chk("R3 packed word", seen[32+2*j], {16'hB000 + 16'(j), 16'hA000 + 16'(j)});
      chk("R3 ovr word", seen[33+2*j], {30'd0, j[0], 1'b1});
    end
    chk("R4 pong address count", 32'(wcount), 24);
    chk("R8 overrun set", 32'(overrun), 1);
  endtask

  task automatic t_overrun;
    int w0;
    w0 = wcount;
    for (int k = 0; k < 4; k++) begin
      strobe(16'h7000, 16'h7001, 1'b0, 1'b0);
      if (k == 1) begin
        @(negedge clk) rel_task = 2'b01;
        @(negedge clk) rel_task = 2'b00;
      end
    end
    chk("R8 dropped frame no writes", 32'(wcount), 32'(w0));
    chk("R8 no irq on dropped", 32'(irqcount), 2);
    chk("R8 sticky", 32'(overrun), 1);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    chk("R10 clear", 32'(overrun), 0);
  endtask

  task automatic t_same_cycle;
    int w0;
    arm_addr = {1'b0, 5'd11}; arm_mask = 2'b10; arm = 1'b1;
    for (int c = 0; c < 4; c++)
      strobe(16'h5000 + 16'(c), 16'h6000 + 16'(c), 1'b0, 1'b1);
    arm = 1'b0;
    chk("R8 retried ping written", seen[0], 32'h5000);
    chk("R7 irq", 32'(irqcount), 3);
    chk("R7 fill ping again", 32'(fill_buf), 0);
    chk("R9 no overrun", 32'(overrun), 0);
    w0 = wcount;
    strobe(16'h9999, 16'h8888, 1'b1, 1'b1);
    chk("R9 next frame written", 32'(wcount - w0), 3);
    chk("R9 pong word", seen[32], 32'h9999);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) seen[i] = 32'hDEAD_BEEF;
    t_reset();
    t_narrow();
    t_wide();
    t_overrun();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=expired exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule